// File: doc/BRIEF.md
# Pushbutton-Stepped ID Digit Display

This block walks through an eight-digit identification number one digit per button press and shows the current digit on a four-digit seven-segment display. A bouncy step pushbutton is filtered on the system clock. Each clean release of the button moves a three-bit position forward by one. A second, active-low pushbutton is sampled at the moment of that release: while it is held, the release returns the position to zero instead of advancing it.

The position selects one of the eight ID digits from a constant parameter and one of the four physical digits. Because there are only four physical digits, positions 4 to 7 land on the same digits as positions 0 to 3, so the fifth ID digit shows up on the leftmost digit again. All logic runs on the system clock. The debounced release is turned into a one-cycle step strobe rather than being used as a clock. A synchronous active-low system reset puts the block in its power-up state.

Top module: `id_step_display`

## Requirements
- R1: While `sys_rst_n` is low at a clock edge, the position becomes 0. The display then shows ID digit 0 on the leftmost digit (`dig_en` = 4'b1000). The debounced step level starts at the released (high) level, so leaving reset does not produce a step.
- R2: A release of the step button advances the position by one when `rst_btn_n` is high at that release. A release is a rise of the filtered level.
- R3: A release while `rst_btn_n` is low sets the position to 0, whatever the current position.
- R4: A release at position 7 with `rst_btn_n` high wraps the position to 0.
- R5: Exactly one bit of `dig_en` is high at a time. `dig_en[3]` (leftmost) is high for position mod 4 = 0, `dig_en[2]` for 1, `dig_en[1]` for 2 and `dig_en[0]` (rightmost) for 3.
- R6: `seg_n[0]` to `seg_n[6]` drive segments a to g and are active low. The shown value is nibble `ID_DIGITS[(7-pos)*4 +: 4]`, so the most significant nibble is ID digit 0. Values 0 to 9 show the standard patterns. Any value above 9 turns off all segments (`seg_n` = 7'h7F).
- R7: A level change on `step_btn` that lasts fewer than `DEBOUNCE_CYCLES` clock cycles is ignored and the position is unchanged.
- R8: Pressing the step button (driving it low) never changes the position, even when the press is held for a long time.
- R9: Changes on `rst_btn_n` while the step button is idle have no effect on the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz in the target) |
| sys_rst_n | input | 1 | Synchronous active-low system reset |
| step_btn | input | 1 | Raw step pushbutton, low while pressed |
| rst_btn_n | input | 1 | Raw reset pushbutton, low while pressed, sampled at a step release |
| seg_n | output | 7 | Active-low segments, bit 0 = a ... bit 6 = g |
| dig_en | output | 4 | Active-high digit enables, bit 3 = leftmost |

## Verification
On every cycle, the assertions check several properties. The step strobe lasts one cycle. The filtered level moves only after the synchronized input has disagreed with it. The position holds, increments, wraps or clears exactly as the strobe and the sampled reset button dictate. The digit enable stays one-hot and a non-decimal value blanks the segments. Other behaviours can only be shown by the bench's scenarios, because they depend on how long a button level persists. These are that bounce and short glitches are absorbed, that a held press never steps, and that the sampled reset button takes effect only at a release.

// File: rtl/idd_pkg.sv
// Shared constants, types and the segment encoder for the ID digit display.
// Assumes a four-digit display and an eight-entry ID of 4-bit digits.
package idd_pkg;
    localparam int NUM_DIGITS = 8;
    localparam int POS_W      = $clog2(NUM_DIGITS);
    localparam int DIGIT_W    = 4;
    localparam int PHYS_DIGITS = 4;
    localparam int SEG_W      = 7;

    typedef logic [POS_W-1:0]   pos_t;
    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   seg_t;

    // Returns the lit-segment mask {g,f,e,d,c,b,a}; values above 9 light nothing.
    function automatic seg_t seg_lit(input digit_t v);
        case (v)
            4'd0:    seg_lit = 7'h3F;
            4'd1:    seg_lit = 7'h06;
            4'd2:    seg_lit = 7'h5B;
            4'd3:    seg_lit = 7'h4F;
            4'd4:    seg_lit = 7'h66;
            4'd5:    seg_lit = 7'h6D;
            4'd6:    seg_lit = 7'h7D;
            4'd7:    seg_lit = 7'h07;
            4'd8:    seg_lit = 7'h7F;
            4'd9:    seg_lit = 7'h6F;
            default: seg_lit = 7'h00;
        endcase
    endfunction
endpackage

// File: rtl/idd_debounce.sv
// Filters a bouncy pushbutton and emits a one-cycle strobe when the filtered
// level rises (button released). Assumes STABLE_CYCLES >= 2. The filtered
// level resets to IDLE_LEVEL, so leaving reset with the button idle is quiet.
module idd_debounce #(
    parameter int   STABLE_CYCLES = 500000,
    parameter logic IDLE_LEVEL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic rise_pulse
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic             sync_a, sync_b;
    logic             level, level_q;
    logic [CNT_W-1:0] cnt;

    // Two-flop synchronizer for the asynchronous button input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= IDLE_LEVEL;
            sync_b <= IDLE_LEVEL;
        end else begin
            sync_a <= raw_in;
            sync_b <= sync_a;
        end
    end

    // Accept a new level only after it has disagreed for STABLE_CYCLES cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= IDLE_LEVEL;
            cnt   <= '0;
        end else if (sync_b == level) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            level <= sync_b;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Rising-edge detector on the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q    <= IDLE_LEVEL;
            rise_pulse <= 1'b0;
        end else begin
            level_q    <= level;
            rise_pulse <= level & ~level_q;
        end
    end

    // The filtered level moves only after the synchronized input disagreed (R7).
    assert_level_follows_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(sync_b) != $past(level)));
    // The stability counter never passes its limit (R7).
    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);
    // A release yields a single-cycle strobe (R2).
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);
    // A falling filtered level (press) never strobes (R8).
    assert_no_strobe_on_press_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_q) |-> !rise_pulse);
endmodule

// File: rtl/idd_position.sv
// Holds the displayed ID position. On a step strobe it clears to zero when
// the synchronized reset button is low, else it advances and wraps after
// the last ID digit. Assumes step is a one-cycle strobe in the clk domain.
module idd_position
    import idd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic rst_btn_n,
    output pos_t pos
);
    localparam pos_t POS_LAST = pos_t'(NUM_DIGITS - 1);

    logic rb_a, rb_sync;
    pos_t pos_next;

    // Synchronize the reset button; it is only consulted at a step strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_a    <= 1'b1;
            rb_sync <= 1'b1;
        end else begin
            rb_a    <= rst_btn_n;
            rb_sync <= rb_a;
        end
    end

    // Next-position logic: clear, or advance with wrap.
    always_comb begin
        if (!rb_sync)              pos_next = '0;
        else if (pos == POS_LAST)  pos_next = '0;
        else                       pos_next = pos + 1'b1;
    end

    // Position register, updated only on a step strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (step) pos <= pos_next;
    end

    // Without a strobe the position holds (R8, R9).
    assert_hold_without_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step) |-> $stable(pos));
    // A strobe with the reset button low clears the position (R3).
    assert_clear_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !rb_sync) |=> (pos == '0));
    // A strobe with the reset button high advances by one (R2).
    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rb_sync && pos != POS_LAST) |=> (pos == $past(pos) + 1'b1));
    // A strobe at the last position wraps to zero (R4).
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rb_sync && pos == POS_LAST) |=> (pos == '0));
endmodule

// File: rtl/idd_decode.sv
// Maps the current position to an ID digit, an active-low segment pattern
// and a one-hot active-high digit enable. Positions wrap onto the four
// physical digits. Clock and reset are used only by the assertions.
module idd_decode
    import idd_pkg::*;
#(
    parameter logic [NUM_DIGITS*DIGIT_W-1:0] ID_DIGITS = 32'h0123_4567
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pos_t                   pos,
    output seg_t                   seg_n,
    output logic [PHYS_DIGITS-1:0] dig_en
);
    localparam int SLOT_W = $clog2(PHYS_DIGITS);

    digit_t             digit_tab [NUM_DIGITS];
    digit_t             digit_sel;
    logic [SLOT_W-1:0]  slot;

    // Unpack the ID constant; ID digit 0 is the most significant nibble.
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_tab
        assign digit_tab[k] = ID_DIGITS[(NUM_DIGITS-1-k)*DIGIT_W +: DIGIT_W];
    end

    // Physical slot is the position modulo the display width.
    assign slot = pos[SLOT_W-1:0];

    // One enable per physical digit, leftmost digit on the top bit.
    for (genvar i = 0; i < PHYS_DIGITS; i++) begin : g_en
        assign dig_en[PHYS_DIGITS-1-i] = (slot == SLOT_W'(i));
    end

    // Select the ID digit and encode it as active-low segments.
    always_comb begin
        digit_sel = digit_tab[pos];
        seg_n     = ~seg_lit(digit_sel);
    end

    // Exactly one digit is enabled at all times (R5).
    assert_onehot_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dig_en) == 1);
    // Non-decimal digits blank the display (R6).
    assert_blank_nondecimal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_sel > 4'd9) |-> (seg_n == 7'h7F));
    // Decimal digits always light at least one segment (R6).
    assert_lit_decimal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_sel <= 4'd9) |-> (seg_n != 7'h7F));
endmodule

// File: rtl/id_step_display.sv
// Top level: debounced step button advances an eight-digit ID position shown
// on a four-digit seven-segment display. Everything runs on clk; the
// debounced release is a strobe, not a clock. Reset is synchronous, active low.
module id_step_display
    import idd_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 500000,
    parameter logic [NUM_DIGITS*DIGIT_W-1:0] ID_DIGITS = 32'h0123_4567
) (
    input  logic       clk,
    input  logic       sys_rst_n,
    input  logic       step_btn,
    input  logic       rst_btn_n,
    output logic [6:0] seg_n,
    output logic [3:0] dig_en
);
    logic step_strobe;
    pos_t pos;

    idd_debounce #(
        .STABLE_CYCLES (DEBOUNCE_CYCLES),
        .IDLE_LEVEL    (1'b1)
    ) u_debounce (
        .clk        (clk),
        .rst_n      (sys_rst_n),
        .raw_in     (step_btn),
        .rise_pulse (step_strobe)
    );

    idd_position u_position (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .step      (step_strobe),
        .rst_btn_n (rst_btn_n),
        .pos       (pos)
    );

    idd_decode #(
        .ID_DIGITS (ID_DIGITS)
    ) u_decode (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .pos    (pos),
        .seg_n  (seg_n),
        .dig_en (dig_en)
    );

    // Reset returns the display to the leftmost digit (R1).
    assert_reset_leftmost_R1: assert property (@(posedge clk)
        !sys_rst_n |=> (dig_en == 4'b1000));
endmodule

// File: tb/sim_id_step_display.sv
module sim_id_step_display;
    localparam int N = 16;
    localparam logic [31:0] ID = 32'h3A90_5718;

    logic       clk = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       step_btn = 1'b1;
    logic       rst_btn_n = 1'b1;
    logic [6:0] seg_n;
    logic [3:0] dig_en;

    int errors = 0;
    int checks = 0;
    int model_pos = 0;
    bit done = 0;

    always #5 clk = ~clk;

    id_step_display #(.DEBOUNCE_CYCLES(N), .ID_DIGITS(ID)) u0 (
        .clk(clk), .sys_rst_n(sys_rst_n), .step_btn(step_btn),
        .rst_btn_n(rst_btn_n), .seg_n(seg_n), .dig_en(dig_en));

    function automatic logic [6:0] exp_seg(input int p);
        logic [3:0] d;
        logic [6:0] on;
        d = ID[(7-p)*4 +: 4];
        case (d)
            0: on = 7'b0111111; 1: on = 7'b0000110; 2: on = 7'b1011011;
            3: on = 7'b1001111; 4: on = 7'b1100110; 5: on = 7'b1101101;
            6: on = 7'b1111101; 7: on = 7'b0000111; 8: on = 7'b1111111;
            9: on = 7'b1101111; default: on = 7'b0000000;
        endcase
        return ~on;
    endfunction

    function automatic logic [3:0] exp_en(input int p);
        return 4'b1000 >> (p % 4);
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req);
        checks++;
        if (seg_n !== exp_seg(model_pos) || dig_en !== exp_en(model_pos)) begin
            errors++;
            $display("FAIL %s: pos=%0d seg_n=%h dig_en=%b expected seg_n=%h dig_en=%b",
                     req, model_pos, seg_n, dig_en, exp_seg(model_pos), exp_en(model_pos));
        end
    endtask

    // Short bounce pulses away from the current level, each under N cycles.
    task automatic bounce(input logic base);
        for (int b = 0; b < 3; b++) begin
            step_btn = ~base;
            wait_cyc(int'($urandom % (N/2)) + 1);
            step_btn = base;
            wait_cyc(int'($urandom % 3) + 1);
        end
    endtask

    // One press/release; rb is the reset-button level held across the release.
    task automatic press(input logic rb, input bit bouncy);
        string tag;
        rst_btn_n = rb;
        if (bouncy) bounce(1'b1);
        step_btn = 1'b0;
        wait_cyc(N + 8);
        check("R8 press held");
        if (bouncy) bounce(1'b0);
        step_btn = 1'b1;
        wait_cyc(N + 8);
        if (!rb)                 begin tag = "R3 clear";   model_pos = 0; end
        else if (model_pos == 7) begin tag = "R4 wrap";    model_pos = 0; end
        else                     begin tag = "R2 advance"; model_pos++;   end
        check(tag);
        rst_btn_n = 1'b1;
        wait_cyc(3);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_1234);
        wait_cyc(5);
        check("R1 reset, R5, R6");
        sys_rst_n = 1'b1;
        wait_cyc(N + 10);
        check("R1 no step after reset");

        // R2 through all positions, then R4 wrap, exercising R5/R6 on each.
        for (int i = 0; i < 8; i++) press(1'b1, 1'b0);
        press(1'b1, 1'b0);
        press(1'b1, 1'b0);

        // R3 clear from a nonzero position.
        press(1'b1, 1'b0);
        press(1'b0, 1'b0);

        // R9: reset button activity with the step button idle.
        press(1'b1, 1'b0);
        rst_btn_n = 1'b0; wait_cyc(N + 5);
        rst_btn_n = 1'b1; wait_cyc(N + 5);
        check("R9 idle reset button");

        // R7: glitches shorter than N, both polarities.
        step_btn = 1'b0; wait_cyc(N - 4); step_btn = 1'b1; wait_cyc(2 * N);
        check("R7 short low glitch");
        step_btn = 1'b0; wait_cyc(1); step_btn = 1'b1; wait_cyc(2 * N);
        check("R7 single-cycle glitch");

        // Random mix of bouncy presses and clears.
        for (int r = 0; r < 40; r++)
            press(($urandom % 4) != 0, ($urandom % 2) == 1);

        // Synchronous reset mid-sequence returns to position 0 (R1).
        press(1'b1, 1'b0);
        sys_rst_n = 1'b0; wait_cyc(3);
        model_pos = 0;
        check("R1 reset mid-sequence");
        sys_rst_n = 1'b1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule